// File: doc/BRIEF.md
# Clocked Serial Shift Port

This block is an 8-bit synchronous serial port for a small controller. One unit can run as clock master, producing the serial clock itself by dividing the system clock by eight. It can also run as a slave that follows a serial clock arriving on an input pin. Both ends shift at the same time, so one transfer swaps the contents of the two shift registers. Data moves least significant bit first. The receiving side samples on the rising clock edge. The sending side changes its data line on the falling edge.

Software writes a 4-bit control word, loads a byte through a valid/ready port and issues a one-cycle start. A slave starts first and raises a ready line. The master's software waits for that line before it issues its own start. After eight rising edges the received byte is offered on a valid/ready output and an interrupt pulse is produced. `load_ready` is low for the whole of a transfer, so a source that holds `load_valid` simply stalls until the port is idle. A received byte stays valid until a consumer takes it with `rx_ready`, or until the next accepted start.

Top module: `sio_port`

## Requirements
- R1: One transfer exchanges full bytes. After it, each side's `rx_data` equals the byte the other side had loaded.
- R2: Bits leave least significant first. `sout` changes only on a serial clock falling edge. `sin` is captured on the rising edge.
- R3: In master mode (`ctrl_wdata[3]`=0) `sck_o` idles high. It first falls 4 system cycles after the start is accepted. It then runs 4 cycles low and 4 cycles high, makes exactly 8 pulses, and stays high afterwards.
- R4: In slave mode (`ctrl_wdata[3]`=1) the port follows `sck_i` through a two-flop synchronizer, with edges detected in the system clock domain.
- R5: Control bits: [1:0]=2'b11 enables the pins, [3] selects the external clock, and [2] marks slave mode. While [1:0] is not 2'b11, `sck_oe` and `sout_oe` are low and `start_i` is ignored.
- R6: In slave mode an accepted start raises `rdy_o` on the next cycle. `rdy_o` drops at the first serial clock falling edge the port sees.
- R7: Until the first falling edge of a transfer, `sout` holds the last bit sent in the previous transfer. After reset it is 1.
- R8: `rx_valid` and a one-cycle `irq` assert together at the 8th rising edge. `rx_valid` clears when `rx_ready` is high or when a new start is accepted.
- R9: `load_ready` is low while a transfer runs, so no byte is taken. A start issued during a transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 4 | Control word: [3] external clock, [2] slave, [1:0] pin enables |
| start_i | input | 1 | Start transfer command (one cycle) |
| load_valid | input | 1 | Byte to send is offered |
| load_ready | output | 1 | Port idle; byte can be taken |
| load_data | input | 8 | Byte to send |
| rx_valid | output | 1 | Received byte available (completion flag) |
| rx_ready | input | 1 | Consumer takes the received byte, clearing the flag |
| rx_data | output | 8 | Received byte |
| irq | output | 1 | One-cycle completion pulse |
| rdy_o | output | 1 | Slave ready indication |
| sck_i | input | 1 | External serial clock |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable |
| sin | input | 1 | Serial data in |
| sout | output | 1 | Serial data out |
| sout_oe | output | 1 | Serial data output enable |

## Verification
The hardest case to reach is the slave's timing margin. The slave sees each clock edge three system cycles late, yet its data must settle before the master's next rising edge. The bench exercises this by wiring a second instance as slave to the master under test and running full exchanges in both directions. It also checks, cycle by cycle, the master's clock level and data line against the expected waveform. A stale-bit check needs a previous transfer whose last bit differs from the reset value, so transfers are chained with chosen top bits.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef struct packed {
    logic       ext_clk;
    logic       slave;
    logic [1:0] pin_en;
  } sio_ctrl_t;
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic fall_ev,
  output logic rise_ev
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          sck_r;
  logic          wrap;

  assign wrap    = run && (cnt == LAST);
  assign fall_ev = wrap && sck_r;
  assign rise_ev = wrap && !sck_r;
  assign sck     = sck_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sck_r <= 1'b1;
    end else if (!run) begin
      cnt   <= '0;
      sck_r <= 1'b1;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) sck_r <= ~sck_r;
    end
  end
endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise_ev,
  output logic fall_ev
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], pin};
  end

  assign rise_ev = pipe[STAGES-1] && !pipe[STAGES];
  assign fall_ev = !pipe[STAGES-1] && pipe[STAGES];
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         begin_ev,
  input  logic         fall_ev,
  input  logic         rise_ev,
  input  logic         sin,
  output logic [W-1:0] shreg,
  output logic         sout,
  output logic         last_ev
);
  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] TOP = BW'(W - 1);

  logic [BW-1:0] bitcnt;

  assign last_ev = rise_ev && (bitcnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      sout   <= 1'b1;
      bitcnt <= '0;
    end else begin
      if (load) shreg <= load_data;
      if (begin_ev) bitcnt <= '0;
      if (fall_ev) sout <= shreg[0];
      if (rise_ev) begin
        shreg  <= {sin, shreg[W-1:1]};
        bitcnt <= bitcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sio_port.sv
module sio_port #(
  parameter int DIV       = 8,
  parameter int W         = 8,
  parameter int SYNC_FLOPS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_we,
  input  logic [3:0]   ctrl_wdata,
  input  logic         start_i,
  input  logic         load_valid,
  output logic         load_ready,
  input  logic [W-1:0] load_data,
  output logic         rx_valid,
  input  logic         rx_ready,
  output logic [W-1:0] rx_data,
  output logic         irq,
  output logic         rdy_o,
  input  logic         sck_i,
  output logic         sck_o,
  output logic         sck_oe,
  input  logic         sin,
  output logic         sout,
  output logic         sout_oe
);
  import sio_pkg::*;

  sio_ctrl_t ctrl;
  logic      busy;
  logic      pins_on;
  logic      start_ok;
  logic      int_sck, int_fall, int_rise;
  logic      ext_fall, ext_rise;
  logic      fall_ev, rise_ev, last_ev;

  assign pins_on    = (ctrl.pin_en == 2'b11);
  assign start_ok   = start_i && !busy && pins_on;
  assign load_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (ctrl_we) ctrl <= sio_ctrl_t'(ctrl_wdata);
  end

  sio_clkgen #(.DIV(DIV)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .run(busy && !ctrl.ext_clk),
    .sck(int_sck), .fall_ev(int_fall), .rise_ev(int_rise)
  );

  sio_edge_sync #(.STAGES(SYNC_FLOPS)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin(sck_i),
    .rise_ev(ext_rise), .fall_ev(ext_fall)
  );

  assign fall_ev = busy && (ctrl.ext_clk ? ext_fall : int_fall);
  assign rise_ev = busy && (ctrl.ext_clk ? ext_rise : int_rise);

  sio_shifter #(.W(W)) shift_i (
    .clk(clk), .rst_n(rst_n),
    .load(load_valid && load_ready), .load_data(load_data),
    .begin_ev(start_ok), .fall_ev(fall_ev), .rise_ev(rise_ev),
    .sin(sin), .shreg(rx_data), .sout(sout), .last_ev(last_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rx_valid <= 1'b0;
      irq      <= 1'b0;
      rdy_o    <= 1'b0;
    end else begin
      irq <= last_ev;
      if (start_ok)     busy <= 1'b1;
      else if (last_ev) busy <= 1'b0;
      if (last_ev)                     rx_valid <= 1'b1;
      else if (start_ok || rx_ready)   rx_valid <= 1'b0;
      if (start_ok && ctrl.slave)      rdy_o <= 1'b1;
      else if (fall_ev || !busy)       rdy_o <= start_ok && ctrl.slave;
    end
  end

  assign sck_o   = ctrl.ext_clk ? 1'b1 : int_sck;
  assign sck_oe  = pins_on && !ctrl.ext_clk;
  assign sout_oe = pins_on;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic load_ready,
  input logic rx_valid,
  input logic irq,
  input logic rdy_o,
  input logic sck_o
);
  assert_idle_sck_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_ready |-> sck_o);
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_done_with_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> irq);
  assert_rdy_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_o) |-> $past(start_i));
  assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_ready) |-> $past(start_i));
endmodule

bind sio_port sio_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_ready(load_ready),
  .rx_valid(rx_valid), .irq(irq), .rdy_o(rdy_o), .sck_o(sck_o)
);

// File: tb/sio_port_tb.sv
module sio_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic       m_we = 0, s_we = 0;
  logic [3:0] m_cw = 0, s_cw = 0;
  logic       m_start = 0, s_start = 0;
  logic       m_lv = 0, s_lv = 0;
  logic [7:0] m_ld = 0, s_ld = 0;
  logic       m_rr = 0, s_rr = 0;
  logic       m_lr, s_lr, m_rv, s_rv, m_irq, s_irq, m_rdy, s_rdy;
  logic [7:0] m_rd, s_rd;
  logic       m_sck, m_sck_oe, m_sout, m_sout_oe;
  logic       s_sck, s_sck_oe, s_sout, s_sout_oe;

  sio_port dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(m_we), .ctrl_wdata(m_cw), .start_i(m_start),
    .load_valid(m_lv), .load_ready(m_lr), .load_data(m_ld), .rx_valid(m_rv),
    .rx_ready(m_rr), .rx_data(m_rd), .irq(m_irq), .rdy_o(m_rdy), .sck_i(1'b1),
    .sck_o(m_sck), .sck_oe(m_sck_oe), .sin(s_sout), .sout(m_sout), .sout_oe(m_sout_oe)
  );

  sio_port slv_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(s_we), .ctrl_wdata(s_cw), .start_i(s_start),
    .load_valid(s_lv), .load_ready(s_lr), .load_data(s_ld), .rx_valid(s_rv),
    .rx_ready(s_rr), .rx_data(s_rd), .irq(s_irq), .rdy_o(s_rdy), .sck_i(m_sck),
    .sck_o(s_sck), .sck_oe(s_sck_oe), .sin(m_sout), .sout(s_sout), .sout_oe(s_sout_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(m_lr == 1'b1, "R9 load_ready after reset", m_lr, 1);
    check(m_sck == 1'b1, "R3 sck idle after reset", m_sck, 1);
    check(m_sout == 1'b1, "R7 sout after reset", m_sout, 1);
    check(m_rv == 1'b0 && m_irq == 1'b0 && m_rdy == 1'b0, "R8 flags after reset",
          {m_rv, m_irq, m_rdy}, 0);
  endtask

  task automatic t_disabled();
    bit moved = 0;
    m_cw = 4'b0001; m_we = 1; tick(); m_we = 0;
    m_start = 1; tick(); m_start = 0;
    for (int i = 0; i < 24; i++) begin
      if (m_sck != 1'b1 || m_lr != 1'b1) moved = 1;
      tick();
    end
    check(!moved, "R5 start ignored with pins off", moved, 0);
    check(m_sck_oe == 0 && m_sout_oe == 0, "R5 output enables off", {m_sck_oe, m_sout_oe}, 0);
  endtask

  task automatic t_exchange(input logic [7:0] mb, input logic [7:0] sb, input logic prev);
    int sck_bad = 0, sout_bad = 0, irq_cnt = 0, irq_at = -1, rises = 0;
    logic last_sck = 1'b1;
    bit slave_had_valid;
    m_cw = 4'b0011; s_cw = 4'b1111; m_we = 1; s_we = 1; tick(); m_we = 0; s_we = 0;
    m_ld = mb; s_ld = sb; m_lv = 1; s_lv = 1; tick(); m_lv = 0; s_lv = 0;
    slave_had_valid = s_rv;
    s_start = 1; tick(); s_start = 0;
    check(s_rdy == 1'b1, "R6 slave ready after start", s_rdy, 1);
    if (slave_had_valid)
      check(s_rv == 1'b0, "R8 new start clears flag", s_rv, 0);
    m_start = 1; tick(); m_start = 0;
    for (int k = 0; k < 70; k++) begin
      logic exp_sck, exp_sout;
      int j;
      exp_sck = (k < 4 || k >= 64) ? 1'b1 : (((k - 4) / 4) % 2 == 1);
      j = (k - 4) / 8; if (j > 7) j = 7;
      exp_sout = (k < 4) ? prev : mb[j];
      if (m_sck != exp_sck) sck_bad++;
      if (m_sout != exp_sout) sout_bad++;
      if (m_sck && !last_sck) rises++;
      last_sck = m_sck;
      if (m_irq) begin irq_cnt++; irq_at = k; end
      if (k == 0)  check(m_sout == prev, "R7 stale bit before first edge", m_sout, prev);
      if (k == 6)  check(s_rdy == 1'b1, "R6 ready held before fall seen", s_rdy, 1);
      if (k == 8)  check(s_rdy == 1'b0, "R6 ready dropped after fall", s_rdy, 0);
      if (k == 10) begin m_lv = 1; m_ld = 8'hEE; end
      if (k == 11) check(m_lr == 1'b0, "R9 load_ready low in transfer", m_lr, 0);
      if (k == 13) m_lv = 0;
      if (k == 20) m_start = 1;
      if (k == 21) m_start = 0;
      if (k == 63) check(m_rv == 1'b0, "R8 flag not early", m_rv, 0);
      if (k == 64) check(m_rv == 1'b1, "R8 flag at 8th rise", m_rv, 1);
      tick();
    end
    check(sck_bad == 0 && rises == 8, "R3 master clock waveform", sck_bad, 0);
    check(sout_bad == 0, "R2 LSB-first sout on falling edges", sout_bad, 0);
    check(irq_cnt == 1 && irq_at == 64, "R8 single irq pulse", irq_at, 64);
    check(m_rd == sb, "R1 master received slave byte (R9 ignored writes)", m_rd, sb);
    for (int w = 0; w < 10 && !s_rv; w++) tick();
    check(s_rv == 1'b1, "R4 slave completed on external clock", s_rv, 1);
    check(s_rd == mb, "R1 slave received master byte", s_rd, mb);
    m_rr = 1; tick(); m_rr = 0;
    check(m_rv == 1'b0, "R8 rx_ready clears flag", m_rv, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_disabled();
    t_exchange(8'h5A, 8'hC3, 1'b1);
    t_exchange(8'hB7, 8'h81, 1'b0);
    t_exchange(8'h00, 8'h6E, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule